// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset for a microprocessor supervisor. It combines two reasons to hold the processor in reset. The first is a supply-good flag from an external threshold comparator, already synchronous to the block clock. The second is an active-low push-button input, which is asynchronous. Reset is held while either reason is present. Once both have cleared, reset is held for a further recovery period counted in clock cycles, and only then released.

The recovery timer is cleared and held at zero for as long as the supply is low, so a supply that dips during recovery restarts the whole period. The same applies when the button is pressed again. A cause that lasts a single clock still yields a reset of at least one full recovery period.

The reset output polarity is chosen at elaboration time. A status bit that is always active-high reports the reset state to a companion watchdog. The default period of 20,000,000 cycles gives 200 ms at 100 MHz, which lies inside the allowed 140 ms to 280 ms window.

Top module: `sup_reset_gen`

## Requirements
- R1: When `supply_ok_i` is sampled low at a rising clock edge, `reset_active_o` is 1 after that edge. It stays 1 for every cycle in which `supply_ok_i` is sampled low.
- R2: After the last asserting cause is sampled clear, `reset_active_o` stays 1 for exactly `REC_CYCLES` further rising edges. It falls on the `REC_CYCLES`-th edge at which no cause is seen.
- R3: Sampling `supply_ok_i` low during recovery clears the timer. The full `REC_CYCLES` count restarts from the first edge at which the supply is sampled high again.
- R4: Every assertion of `reset_active_o` lasts at least `REC_CYCLES` cycles, even when its cause is present for only one cycle.
- R5: `man_rst_ni` passes through a two-stage synchronizer. A low level sampled at edge k asserts `reset_active_o` after edge k+2. A low pulse of two clocks, which is 20 ns at 100 MHz and so shorter than the required 150 ns minimum, yields a full recovery period. The release of the input becomes visible to the timer two edges after it is sampled.
- R6: With `POLARITY` = `POL_LOW`, `reset_o` is the inverse of `reset_active_o`. With `POL_HIGH`, `reset_o` equals `reset_active_o`.
- R7: A new low on `man_rst_ni` during recovery reloads the timer. The full period then restarts after the input is released again.
- R8: While `rst_ni` is low, `reset_active_o` is 1 and the timer is zero. With no cause present, reset is released on the `REC_CYCLES`-th rising edge after `rst_ni` rises.
- R9: `reset_active_o` is 1 exactly when the reset output is in its asserted state, whatever the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset of the block |
| supply_ok_i | input | 1 | Synchronous flag from the supply comparator, 1 = supply above threshold |
| man_rst_ni | input | 1 | Asynchronous active-low push-button reset request |
| reset_o | output | 1 | Reset to the processor, polarity set by `POLARITY` |
| reset_active_o | output | 1 | Active-high reset status for a companion watchdog |

## Verification
The supply cause and the push-button cause can become active, and clear, in the same cycle. They reach the timer with different latencies: the supply flag takes effect at once, while the button passes through the synchronizer first. The bench drops both together, then releases the supply while the button is still held, and later releases both on the same clock. In the shared-release case, the release must come 18 cycles later with a 16-cycle period, because the synchronizer latency governs. A release at 16 cycles would show that the supply path alone was used, and the bench flags it.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } pol_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sup_mr_sync.sv
module sup_mr_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RESET_VAL;
        else         chain_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RESET_VAL;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sup_recovery_timer.sv
module sup_recovery_timer #(
  parameter int unsigned REC_CYCLES = 20_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  output logic active_o
);

  localparam int unsigned CNT_W = sup_reset_pkg::cnt_width(REC_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  // any cause clears and holds the count; release on the last quiet cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (cause_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/sup_reset_drive.sv
module sup_reset_drive #(
  parameter sup_reset_pkg::pol_e POLARITY = sup_reset_pkg::POL_LOW
) (
  input  logic active_i,
  output logic reset_o
);

  if (POLARITY == sup_reset_pkg::POL_HIGH) begin : g_high
    assign reset_o = active_i;
  end else begin : g_low
    assign reset_o = ~active_i;
  end

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int unsigned         REC_CYCLES  = 20_000_000,
  parameter int unsigned         SYNC_STAGES = 2,
  parameter sup_reset_pkg::pol_e POLARITY    = sup_reset_pkg::POL_LOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic man_rst_ni,
  output logic reset_o,
  output logic reset_active_o
);

  logic mr_sync_n;
  logic cause;
  logic active;

  sup_mr_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_mr_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(man_rst_ni),
    .sync_o (mr_sync_n)
  );

  assign cause = ~supply_ok_i | ~mr_sync_n;

  sup_recovery_timer #(
    .REC_CYCLES(REC_CYCLES)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cause_i (cause),
    .active_o(active)
  );

  sup_reset_drive #(
    .POLARITY(POLARITY)
  ) u_drive (
    .active_i(active),
    .reset_o (reset_o)
  );

  assign reset_active_o = active;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter int unsigned REC_CYCLES = 20_000_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic man_rst_ni,
  input logic reset_active_o
);

  localparam int unsigned W = $clog2(REC_CYCLES + 1) + 1;
  localparam logic [W-1:0] SAT = W'(REC_CYCLES);

  logic [1:0]   age_q;
  logic [W-1:0] run_q;
  logic [W-1:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q   <= '0;
      run_q   <= '0;
      quiet_q <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (!reset_active_o)  run_q <= '0;
      else if (run_q < SAT) run_q <= run_q + 1'b1;
      if (!supply_ok_i)       quiet_q <= '0;
      else if (quiet_q < SAT) quiet_q <= quiet_q + 1'b1;
    end
  end

  p_supply_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> reset_active_o);

  p_mr_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && !$past(man_rst_ni, 2)) |=> reset_active_o);

  p_min_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_active_o && run_q < SAT - 1'b1) |=> reset_active_o);

  p_quiet_before_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_active_o) |-> quiet_q >= SAT);

  p_release_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reset_active_o && supply_ok_i && man_rst_ni && $past(man_rst_ni)
     && $past(man_rst_ni, 2) && age_q >= 2'd2) |=> !reset_active_o);

endmodule

bind sup_reset_gen sup_reset_gen_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .supply_ok_i   (supply_ok_i),
  .man_rst_ni    (man_rst_ni),
  .reset_active_o(reset_active_o)
);

// File: tb/tb_sup_reset_gen.sv
`timescale 1ns/1ps
module tb_sup_reset_gen;

  localparam int unsigned REC = 16;

  typedef struct packed {
    logic       sok;
    logic       mrn;
    logic [7:0] n;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // drive sok/mrn, wait n cycles, expect reset_active
  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 8'd1,  1'b1, 4'd1},  // R1 supply drop
    '{1'b0, 1'b1, 8'd40, 1'b1, 4'd1},  // R1 held
    '{1'b1, 1'b1, 8'd15, 1'b1, 4'd2},  // R2 still counting
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd2},  // R2 released at 16
    '{1'b1, 1'b0, 8'd2,  1'b0, 4'd5},  // R5 sync latency
    '{1'b1, 1'b0, 8'd1,  1'b1, 4'd5},  // R5 asserted after 3rd edge
    '{1'b1, 1'b1, 8'd17, 1'b1, 4'd5},
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd5},
    '{1'b1, 1'b0, 8'd2,  1'b0, 4'd4},  // R4 two-clock pulse
    '{1'b1, 1'b1, 8'd1,  1'b1, 4'd4},
    '{1'b1, 1'b1, 8'd16, 1'b1, 4'd4},
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd4},
    '{1'b1, 1'b0, 8'd3,  1'b1, 4'd7},  // R7 retrigger
    '{1'b1, 1'b1, 8'd10, 1'b1, 4'd7},
    '{1'b1, 1'b0, 8'd5,  1'b1, 4'd7},
    '{1'b1, 1'b1, 8'd17, 1'b1, 4'd7},
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd7},
    '{1'b0, 1'b1, 8'd1,  1'b1, 4'd3},  // R3 dip during recovery
    '{1'b1, 1'b1, 8'd10, 1'b1, 4'd3},
    '{1'b0, 1'b1, 8'd3,  1'b1, 4'd3},
    '{1'b1, 1'b1, 8'd15, 1'b1, 4'd3},
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd3},
    '{1'b0, 1'b0, 8'd3,  1'b1, 4'd1},  // both causes together
    '{1'b1, 1'b0, 8'd20, 1'b1, 4'd1},
    '{1'b1, 1'b1, 8'd17, 1'b1, 4'd2},
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd2},
    '{1'b0, 1'b0, 8'd5,  1'b1, 4'd2},  // shared release
    '{1'b1, 1'b1, 8'd17, 1'b1, 4'd2},
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd2},
    '{1'b0, 1'b1, 8'd1,  1'b1, 4'd4},  // R4 one-cycle glitch
    '{1'b1, 1'b1, 8'd15, 1'b1, 4'd4},
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sok = 1'b1;
  logic mrn = 1'b1;
  logic rst_lo, act_lo, rst_hi, act_hi;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  sup_reset_gen #(.REC_CYCLES(REC), .POLARITY(sup_reset_pkg::POL_LOW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sok), .man_rst_ni(mrn),
    .reset_o(rst_lo), .reset_active_o(act_lo));

  sup_reset_gen #(.REC_CYCLES(REC), .POLARITY(sup_reset_pkg::POL_HIGH)) dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sok), .man_rst_ni(mrn),
    .reset_o(rst_hi), .reset_active_o(act_hi));

  function automatic string req_name(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic exp, input string req);
    checks++;
    if (act_lo !== exp || act_hi !== exp) begin
      fails++;
      $display("FAIL %s: reset_active lo=%b hi=%b expected %b at %0t", req, act_lo, act_hi, exp, $time);
    end
    // R6 / R9 polarity of the pin against the status bit
    if (rst_lo !== ~exp || rst_hi !== exp) begin
      fails++;
      $display("FAIL R6/R9 (%s): reset_o lo=%b hi=%b expected lo=%b hi=%b", req, rst_lo, rst_hi, ~exp, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    check(1'b1, "R8");
    @(negedge clk);
    check(1'b1, "R8");
    rst_n = 1'b1;
    repeat (REC - 1) @(negedge clk);
    check(1'b1, "R8");
    @(negedge clk);
    check(1'b0, "R8");
    for (int i = 0; i < NV; i++) begin
      sok = VEC[i].sok;
      mrn = VEC[i].mrn;
      repeat (int'(VEC[i].n)) @(negedge clk);
      check(VEC[i].exp, req_name(int'(VEC[i].req)));
    end
    // directed: reset in the middle of an assertion returns to the R8 state
    sok = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    sok = 1'b1;
    @(negedge clk);
    check(1'b1, "R8");
    rst_n = 1'b1;
    repeat (REC) @(negedge clk);
    check(1'b0, "R8");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule